// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer with a parameterised number of independent channels (four by default). All channels run from the same clock. Each channel holds a 64-bit interval, set through a low and a high 32-bit word, and a 64-bit down-counter that can be read back. A small control word per channel sets run enable, a load request, a power-of-two prescaler and the choice between one-shot and periodic operation. When a counter runs out it raises a sticky pending flag. Software clears the flag by writing a one to it.

A single interrupt line is the OR of the pending flags whose per-channel interrupt enable is set. In a typical setup one channel is left free-running with an all-ones interval, so that software can invert its count to get a rising timestamp. The other channels are programmed for single deadlines or for a periodic tick. Software must wait at least three clock cycles after disabling a channel before it reprograms that channel.

The bus port is synchronous and word-addressed. A write takes effect at the clock edge where `wr_en_i` is high. Read data is captured at the clock edge where `rd_en_i` is high and is held until the next read.

Top module: `mc_down_timer`

## Requirements
- R1: After reset every register reads 0, `rdata_o` is 0 and `irq_o` is low.
- R2: `addr_i` is a word address (byte offset / 4). The interrupt-enable register is word 0 and the pending register is word 1. Channel n has control at word 8n+4, interval low at 8n+5, interval high at 8n+6, count low at 8n+7 and count high at 8n+8. Any other word reads 0, and a write to it changes nothing. The two count words are read-only.
- R3: Control word fields are: bit 0 enable, bit 1 load request, bits 6:4 prescaler select, bit 7 one-shot (0 = periodic). The load request bit always reads 0, and bits 3:2 read 0.
- R4: A control write at edge W that sets both enable and load copies the 64-bit interval into the counter at edge W+1 and restarts the prescaler. A load request written with enable 0 leaves the counter unchanged.
- R5: With select s, the count decrements once every 2^s cycles. After load edge L, the count after edge L+m is I − floor(m/2^s), until it reaches zero.
- R6: A counter that is zero when a prescaler tick arrives sets its pending bit at that edge. In periodic mode it reloads the interval, so expiries fall at L+k·(I+1)·2^s.
- R7: In one-shot mode the expiring edge clears the channel's enable bit, and the count stays at 0.
- R8: Clearing enable freezes the count and the prescaler. Interval writes and a new load issued three or more cycles later fully take effect.
- R9: Writing 1 to a pending bit clears it and writing 0 leaves it alone. If an expiry and a clear of the same bit fall on the same edge, the bit ends up set.
- R10: `irq_o` is high in the cycle after any edge that leaves some channel with both its interrupt-enable bit and its pending bit at 1. It is low otherwise.
- R11: `rdata_o` changes only at an edge where `rd_en_i` is high.
- R12: The interval high word is loaded together with the low word, and the count high word returns the upper 32 counter bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
A control write at edge W loads at W+1. Counter steps, expiries and one-shot enable clears then land on edges L+m·2^s counted from that load edge. Pending and interrupt changes appear in the cycle after the edge that causes them. A read captures state at its own edge, so it reports what the previous edge left. The bench records the index of every bus edge from its own cycle counter and samples all outputs at the following falling edge. It converts each read edge back to "state after edge R−1" and evaluates the closed-form count and expiry formulas there. It also places the same-edge clear collision exactly on a computed expiry edge.

// File: rtl/mcdt_pkg.sv
package mcdt_pkg;
  localparam int SEL_W           = 3;
  localparam int IE_WORD         = 0;
  localparam int ST_WORD         = 1;
  localparam int CH_BASE_WORD    = 4;
  localparam int CH_STRIDE_WORDS = 8;
  localparam int CH_FIELDS       = 5;

  typedef enum logic [2:0] {
    FLD_CTRL = 3'd0,
    FLD_ILO  = 3'd1,
    FLD_IHI  = 3'd2,
    FLD_CLO  = 3'd3,
    FLD_CHI  = 3'd4,
    FLD_NONE = 3'd7
  } fld_e;

  typedef struct packed {
    logic             oneshot;
    logic [SEL_W-1:0] sel;
    logic             reload;
    logic             en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [7:0] b);
    ctrl_t c;
    c.oneshot = b[7];
    c.sel     = b[6:4];
    c.reload  = b[1];
    c.en      = b[0];
    return c;
  endfunction

  // load request never reads back
  function automatic logic [7:0] ctrl_pack(input ctrl_t c);
    return {c.oneshot, c.sel, 2'b00, 1'b0, c.en};
  endfunction
endpackage

// File: rtl/mcdt_prescaler.sv
module mcdt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] lim;
  logic [PW:0]   pow;

  always_comb begin
    pow = {{PW{1'b0}}, 1'b1} << sel_i;
    lim = PW'(pow - (PW+1)'(1));
  end

  assign tick_o = run_i & (pcnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (restart_i) pcnt_q <= '0;
    else if (run_i)     pcnt_q <= tick_o ? '0 : pcnt_q + PW'(1);
  end
endmodule

// File: rtl/mcdt_channel.sv
module mcdt_channel
  import mcdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ilo_we_i,
  input  logic              ihi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  ival_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_o
);
  localparam int HI_W = CNT_W - DATA_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] ival_q, cnt_q;
  logic             load, run, tick, at_zero;

  assign load    = ctrl_q.en & ctrl_q.reload;
  assign run     = ctrl_q.en & ~ctrl_q.reload;
  assign at_zero = (cnt_q == '0);

  mcdt_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(load),
    .run_i    (run),
    .sel_i    (ctrl_q.sel),
    .tick_o   (tick)
  );

  assign expire_o = run & tick & at_zero;

  // software write wins over hardware self-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_unpack(wdata_i[7:0]);
    else begin
      if (load) ctrl_q.reload <= 1'b0;
      if (expire_o && ctrl_q.oneshot) ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ival_q <= '0;
    else begin
      if (ilo_we_i) ival_q[DATA_W-1:0]     <= wdata_i;
      if (ihi_we_i) ival_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load) cnt_q <= ival_q;
    else if (run && tick) begin
      if (at_zero) cnt_q <= ctrl_q.oneshot ? '0 : ival_q;
      else         cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign ctrl_o = ctrl_q;
  assign ival_o = ival_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/mcdt_irq_ctrl.sv
module mcdt_irq_ctrl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ie_we_i,
  input  logic              st_we_i,
  input  logic [NUM_CH-1:0] wmask_i,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] ie_o,
  output logic [NUM_CH-1:0] st_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ie_q, st_q, clr;

  assign clr = st_we_i ? wmask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= '0;
      st_q <= '0;
    end else begin
      if (ie_we_i) ie_q <= wmask_i;
      st_q <= set_i | (st_q & ~clr);  // set beats clear
    end
  end

  assign ie_o  = ie_q;
  assign st_o  = st_q;
  assign irq_o = |(ie_q & st_q);
endmodule

// File: rtl/mc_down_timer.sv
module mc_down_timer
  import mcdt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl_a [NUM_CH];
  logic [CNT_W-1:0]  ival_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [NUM_CH-1:0] exp_a, hit_ch, ie_vec, st_vec;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  fld_e              fld;
  logic              ie_hit, st_hit;

  assign ie_hit = (int'(addr_i) == IE_WORD);
  assign st_hit = (int'(addr_i) == ST_WORD);

  always_comb begin
    hit_ch = '0;
    fld    = FLD_NONE;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int f = 0; f < CH_FIELDS; f++) begin
        if (int'(addr_i) == CH_BASE_WORD + c * CH_STRIDE_WORDS + f) begin
          hit_ch[c] = 1'b1;
          fld       = fld_e'(3'(f));
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mcdt_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctrl_we_i(wr_en_i & hit_ch[c] & (fld == FLD_CTRL)),
      .ilo_we_i (wr_en_i & hit_ch[c] & (fld == FLD_ILO)),
      .ihi_we_i (wr_en_i & hit_ch[c] & (fld == FLD_IHI)),
      .wdata_i  (wdata_i),
      .ctrl_o   (ctrl_a[c]),
      .ival_o   (ival_a[c]),
      .cnt_o    (cnt_a[c]),
      .expire_o (exp_a[c])
    );
  end

  mcdt_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ie_we_i(wr_en_i & ie_hit),
    .st_we_i(wr_en_i & st_hit),
    .wmask_i(wdata_i[NUM_CH-1:0]),
    .set_i  (exp_a),
    .ie_o   (ie_vec),
    .st_o   (st_vec),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (ie_hit) rd_mux = DATA_W'(ie_vec);
    if (st_hit) rd_mux = DATA_W'(st_vec);
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_ch[c]) begin
        case (fld)
          FLD_CTRL: rd_mux = DATA_W'(ctrl_pack(ctrl_a[c]));
          FLD_ILO:  rd_mux = ival_a[c][DATA_W-1:0];
          FLD_IHI:  rd_mux = DATA_W'(ival_a[c][CNT_W-1:DATA_W]);
          FLD_CLO:  rd_mux = cnt_a[c][DATA_W-1:0];
          FLD_CHI:  rd_mux = DATA_W'(cnt_a[c][CNT_W-1:DATA_W]);
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mcdt_checker.sv
module mcdt_checker
  import mcdt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] st_vec,
  input logic [NUM_CH-1:0] exp_a,
  input ctrl_t             ctrl_a [NUM_CH],
  input logic [CNT_W-1:0]  cnt_a  [NUM_CH]
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    int w;
    w = int'(a);
    if (w == IE_WORD || w == ST_WORD) return 1'b1;
    if (w < CH_BASE_WORD) return 1'b0;
    return ((w - CH_BASE_WORD) / CH_STRIDE_WORDS < NUM_CH) &&
           ((w - CH_BASE_WORD) % CH_STRIDE_WORDS < CH_FIELDS);
  endfunction

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !is_mapped(addr_i)) |=> (rdata_o == '0)); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && int'(addr_i) == ST_WORD) |=> ((st_vec & $past(st_vec)) == $past(st_vec))); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exp_a[c] |=> st_vec[c]); // R6

    AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exp_a[c] && ctrl_a[c].oneshot && !wr_en_i) |=> !ctrl_a[c].en); // R7

    AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_a[c].en |=> $stable(cnt_a[c])); // R8

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_a[c].en && !ctrl_a[c].reload && cnt_a[c] != '0) |=>
      (cnt_a[c] == $past(cnt_a[c]) || cnt_a[c] == $past(cnt_a[c]) - CNT_W'(1))); // R5

    AST_LOAD_BIT_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && int'(addr_i) == CH_BASE_WORD + c * CH_STRIDE_WORDS) |=> !rdata_o[1]); // R3
  end
endmodule

bind mc_down_timer mcdt_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .st_vec (st_vec),
  .exp_a  (exp_a),
  .ctrl_a (ctrl_a),
  .cnt_a  (cnt_a)
);

// File: tb/sim_mc_down_timer.sv
module sim_mc_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          cyc = 0;
  int          last_edge = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  mc_down_timer u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .wr_en_i(wr),
    .rd_en_i(rd),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int w_ctrl(int c); return 4 + 8 * c; endfunction
  function automatic int w_ilo(int c);  return 5 + 8 * c; endfunction
  function automatic int w_ihi(int c);  return 6 + 8 * c; endfunction
  function automatic int w_clo(int c);  return 7 + 8 * c; endfunction
  function automatic int w_chi(int c);  return 8 + 8 * c; endfunction

  // count after m cycles since load, interval iv, prescale p
  function automatic longint unsigned exp_cnt(longint unsigned iv, int p, bit os, int m);
    longint unsigned t;
    t = longint'(m / p);
    if (os) return (t <= iv) ? iv - t : 64'd0;
    return iv - (t % (iv + 1));
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    wr = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
    last_edge = cyc;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    rd = 1'b1; addr = 6'(a);
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
    last_edge = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns load edge
  task automatic start_ch(input int c, input logic [31:0] iv, input int sel, input bit os, output int ld);
    bus_wr(w_ilo(c), iv);
    bus_wr(w_ihi(c), 32'd0);
    bus_wr(w_ctrl(c), (32'(os) << 7) | (32'(sel) << 4) | 32'h3);
    ld = last_edge + 1;
  endtask

  task automatic cleanup(input int c);
    bus_wr(w_ctrl(c), 32'd0);
    idle(3);
    bus_wr(1, 32'hF);
    bus_wr(0, 32'd0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report;
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int ld, e, sd;
    sd = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", irq, 0);
    bus_rd(0, d);        chk("R1 ie", d, 0);
    bus_rd(1, d);        chk("R1 status", d, 0);
    bus_rd(w_ctrl(0), d); chk("R1 ctrl0", d, 0);
    bus_rd(w_clo(3), d); chk("R1 cnt3", d, 0);

    // R2 unmapped and readback
    bus_wr(2, 32'hFFFF_FFFF);
    bus_rd(2, d);  chk("R2 unmapped w2", d, 0);
    bus_rd(9, d);  chk("R2 unmapped w9", d, 0);
    bus_rd(36, d); chk("R2 unmapped w36", d, 0);
    bus_rd(0, d);  chk("R2 ignored write ie", d, 0);
    bus_wr(w_ilo(2), 32'h1234_5678);
    bus_rd(w_ilo(2), d); chk("R2 ilo readback", d, 32'h1234_5678);

    // R11 read data held
    idle(3);
    chk("R11 hold idle", rdata, 32'h1234_5678);
    bus_wr(0, 32'h5);
    chk("R11 hold write", rdata, 32'h1234_5678);
    bus_wr(0, 32'h0);

    // R3/R4 control fields, load needs enable
    bus_wr(w_ilo(1), 32'd7);
    bus_wr(w_ctrl(1), 32'hF2);
    bus_rd(w_ctrl(1), d); chk("R3 ctrl readback", d, 32'hF0);
    bus_rd(w_clo(1), d);  chk("R4 no load while disabled", d, 0);
    bus_wr(w_ctrl(1), 32'd0);

    // R12 wide interval, R2 count read-only
    bus_wr(w_ilo(2), 32'd10);
    bus_wr(w_ihi(2), 32'd5);
    bus_wr(w_ctrl(2), 32'h73);
    idle(2);
    bus_rd(w_chi(2), d); chk("R12 count hi", d, 5);
    bus_rd(w_clo(2), d); chk("R12 count lo", d, 10);
    bus_wr(w_clo(2), 32'd0);
    bus_rd(w_clo(2), d); chk("R2 count read-only", d, 10);
    cleanup(2);

    // R4/R8 load timing, freeze, reprogram
    start_ch(0, 32'd100, 0, 1'b0, ld);
    idle(10);
    bus_wr(w_ctrl(0), 32'd0);
    e = last_edge;
    bus_rd(w_clo(0), d);
    chk("R8 frozen value", d, 32'(exp_cnt(100, 1, 1'b0, e - ld)));
    idle(5);
    bus_rd(w_clo(0), d2); chk("R8 frozen hold", d2, d);
    idle(3);
    start_ch(0, 32'd4, 0, 1'b0, ld);
    idle(1);
    bus_rd(w_clo(0), d); chk("R4 load edge", d, 4);
    idle(5);
    bus_rd(w_clo(0), d);
    chk("R6 periodic reload", d, 32'(exp_cnt(4, 1, 1'b0, last_edge - 1 - ld)));
    cleanup(0);

    // R7 one-shot directed
    start_ch(1, 32'd3, 1, 1'b1, ld);
    idle(12);
    bus_rd(w_clo(1), d);  chk("R7 stays zero", d, 0);
    bus_rd(w_ctrl(1), d); chk("R7 enable cleared", d, 32'h90);
    bus_rd(1, d);         chk("R6 oneshot status", d, 32'h2);
    cleanup(1);

    // R9/R10 set beats clear, mask
    bus_wr(0, 32'h8);
    start_ch(3, 32'd3, 0, 1'b0, ld);
    idle(4);
    bus_wr(1, 32'h8);   // lands on expiry edge
    chk("R9 set beats clear", last_edge, ld + 4);
    chk("R10 irq on expiry", irq, 1);
    bus_rd(1, d);        chk("R9 status kept", d, 32'h8);
    bus_wr(1, 32'h8);
    chk("R9 irq after clear", irq, 0);
    bus_rd(1, d);        chk("R9 status cleared", d, 0);
    idle(2);
    chk("R10 irq next expiry", irq, 1);
    bus_wr(0, 32'h0);    chk("R10 masked", irq, 0);
    bus_wr(0, 32'h8);    chk("R10 unmasked", irq, 1);
    cleanup(3);
    chk("R9 cleared all", irq, 0);

    // random runs
    for (int it = 0; it < 60; it++) begin
      int c, sel, p, k, xe;
      bit os;
      longint unsigned iv;
      c   = int'($urandom % 4);
      iv  = 3 + longint'($urandom % 10);
      sel = int'($urandom % 3);
      os  = 1'($urandom % 2);
      p   = 1 << sel;
      k   = 1 + int'($urandom % ((int'(iv) + 1) * p + 6));
      bus_wr(0, 32'(1 << c));
      start_ch(c, 32'(iv), sel, os, ld);
      xe = ld + (int'(iv) + 1) * p;
      idle(k);
      bus_rd(w_clo(c), d);
      e = last_edge - 1;
      chk(os ? "R7 rand count" : "R5 rand count", d, 32'(exp_cnt(iv, p, os, e - ld)));
      chk("R10 rand irq", irq, (last_edge >= xe) ? 1 : 0);
      bus_rd(1, d);
      chk("R6 rand status", d, ((last_edge - 1) >= xe) ? 32'(1 << c) : 0);
      bus_rd(w_ctrl(c), d);
      chk("R7 rand enable", d[0], (os && (last_edge - 1) >= xe) ? 0 : 1);
      cleanup(c);
    end

    report;
    $finish;
  end
endmodule